// File: doc/BRIEF.md
# Indexed Extension Word Address Calculator

This block resolves the effective address of an indexed operand from the extension word that follows an instruction opcode. At the start it samples the extension word, a base value and one index register. The base value is either an address register or the program counter. The index register is read through a 16-entry register-file read port, whose select is driven straight from the extension word. Two encodings are handled. In the short encoding, the address is base plus scaled index plus an 8-bit signed offset. In the long encoding, the base can be dropped and the displacements can be absent, one word or two words. An optional pointer fetch from memory can also be added, with the index applied either before or after that fetch.

Any displacement words that follow are pulled in order from an instruction-word port with a request/acknowledge handshake. The pointer used by memory indirection is read as two 16-bit halves through a separate read port, and a read error there ends the calculation. Each calculation ends with a one-cycle `done` pulse. At that pulse the block shows either the address, an illegal-encoding flag or a fault flag.

Top module: `idx_ea_calc`

## Requirements
- R1: With extension bit 8 clear (short encoding), `done` rises exactly one cycle after `start` is taken and `eaOut` = base + scaled index + bits 7:0 sign-extended; no word fetch and no memory read occur.
- R2: The index register number is extension bits 15:12 (shown on `regSel`); bit 11 = 0 uses the low 16 bits of `regData` sign-extended, bit 11 = 1 uses all 32 bits.
- R3: The index is shifted left by extension bits 10:9 (factor 1, 2, 4 or 8) before use.
- R4: With bit 8 set (long encoding), bit 7 = 1 replaces the base value by zero.
- R5: The base displacement code is bits 5:4: 0 or 1 give zero with no word fetched, 2 fetches one word and sign-extends it, 3 fetches two words, the more significant first.
- R6: The outer displacement code is bits 1:0 with the same word meaning; code 0 disables memory indirection and codes 1 to 3 enable it. Base displacement words are fetched before outer displacement words.
- R7: Bits 6 and 2 select the index use: both 0 adds the index before the pointer fetch; bit 2 only adds it after the fetch; bit 6 only drops it. Without indirection the index counts only in the first case.
- R8: In the long encoding, bits 6 and 2 both set, or bit 3 set, is illegal: `done` with `illegal` = 1 and `eaOut` = 0 one cycle after `start`, with no fetch and no read.
- R9: With indirection, the pointer's upper half is read at the inner address and its lower half at inner address + 2. The result is pointer + outer displacement (+ index when post-indexed). The latency is 1 + words fetched + 2 cycles when every handshake completes at once.
- R10: An error response on either pointer read gives `done` with `fault` = 1 and `eaOut` = 0 in the cycle after that response, and no further read is issued.
- R11: `start` is ignored while `busy` is high; a calculation produces exactly one `done` pulse and its result is not disturbed.
- R12: During reset `busy`, `done`, `fetchReq` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calculation (taken when not busy) |
| extWord | input | 16 | Index extension word, sampled with start |
| baseVal | input | 32 | Base register or PC value, sampled with start |
| regSel | output | 4 | Register-file read select for the index register |
| regData | input | 32 | Register-file read data for regSel |
| fetchReq | output | 1 | Request for the next instruction word |
| fetchAck | input | 1 | Instruction word supplied this cycle |
| fetchWord | input | 16 | Instruction word data |
| memReq | output | 1 | Pointer half-word read request |
| memAddr | output | 32 | Pointer read address |
| memAck | input | 1 | Read response this cycle |
| memErr | input | 1 | Read response is an error |
| memData | input | 16 | Read response data |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| eaOut | output | 32 | Effective address, valid with done |
| illegal | output | 1 | Illegal encoding, valid with done |
| fault | output | 1 | Pointer read error, valid with done |

## Verification
The short encoding and the illegal cases are due on the first cycle after the sampling edge. A long-encoding result is due 1 + N cycles after that edge, where N is the number of displacement words plus the two pointer reads. A read error moves that due cycle earlier to the cycle after the failing response. The bench models every word fetch and memory response with an immediate acknowledge. It counts falling edges from the sampling edge until `done`, compares that count with the latency computed from the encoding, and reads `eaOut` and the flags at that same falling edge. A run with a stalling word port checks only the values, because its latency is set by the stalls.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int ADDR_W = 32;
  localparam int HALF_W = 16;
  localparam int EXT_W = 16;
  localparam int HALF_BYTES = HALF_W / 8;

  // decoded view of the extension word
  typedef struct packed {
    logic brief;
    logic suppress;
    logic illegal;
    logic preIdx;
    logic postIdx;
    logic indir;
    logic [1:0] bdCode;
    logic [1:0] odCode;
  } ext_cfg_t;

  // subset the sequencer needs
  typedef struct packed {
    logic brief;
    logic illegal;
    logic indir;
    logic [1:0] bdCode;
    logic [1:0] odCode;
  } seq_cfg_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic capture;
    logic bdFirst;
    logic bdSecond;
    logic odFirst;
    logic odSecond;
    logic ptrFirst;
    logic ptrSecond;
    logic selLow;
    logic setFault;
  } dp_strobe_t;

  function automatic ext_cfg_t decodeExt(input logic [8:0] e);
    ext_cfg_t c;
    c.brief    = !e[8];
    c.suppress = e[8] & e[7];
    c.illegal  = e[8] & ((e[6] & e[2]) | e[3]);
    c.preIdx   = !e[6] & !e[2];
    c.postIdx  = e[2] & !e[6];
    c.indir    = e[8] & (e[1:0] != 2'd0);
    c.bdCode   = e[5:4];
    c.odCode   = e[1:0];
    return c;
  endfunction

  function automatic seq_cfg_t toSeq(input ext_cfg_t c);
    seq_cfg_t s;
    s.brief   = c.brief;
    s.illegal = c.illegal;
    s.indir   = c.indir;
    s.bdCode  = c.bdCode;
    s.odCode  = c.odCode;
    return s;
  endfunction
endpackage

// File: rtl/idx_ea_disp.sv
module idx_ea_disp #(
  parameter int AW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          ldFirst,
  input  logic          ldSecond,
  input  logic          isLong,
  input  logic [HW-1:0] word,
  output logic [AW-1:0] value
);
  localparam int PAD_W = AW - HW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (ldFirst) begin
      // long form takes the upper half first; word form sign-extends
      value <= isLong ? {word, {PAD_W{1'b0}}} : {{PAD_W{word[HW-1]}}, word};
    end else if (ldSecond) begin
      value[HW-1:0] <= word;
    end
  end
endmodule

// File: rtl/idx_ea_dp.sv
module idx_ea_dp
  import idx_ea_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic [11:0]       extLow,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] regData,
  input  logic [HALF_W-1:0] fetchWord,
  input  logic [HALF_W-1:0] memData,
  output seq_cfg_t          seqIn,
  output seq_cfg_t          seqQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] eaOut,
  output logic              illegal,
  output logic              fault
);
  localparam int LOW8_W = 8;

  ext_cfg_t          cfgIn;
  ext_cfg_t          cfgQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] idxQ;
  logic [ADDR_W-1:0] disp8Q;
  logic [ADDR_W-1:0] ptrQ;
  logic              faultQ;
  logic [ADDR_W-1:0] idxSel;
  logic [ADDR_W-1:0] idxScaled;
  logic [ADDR_W-1:0] dispVal [2];
  logic [ADDR_W-1:0] innerAddr;
  logic [ADDR_W-1:0] outerAddr;

  assign cfgIn = decodeExt(extLow[8:0]);
  assign seqIn = toSeq(cfgIn);
  assign seqQ  = toSeq(cfgQ);

  // index width select and scale
  always_comb begin
    idxSel    = extLow[11] ? regData
                           : {{(ADDR_W-HALF_W){regData[HALF_W-1]}}, regData[HALF_W-1:0]};
    idxScaled = idxSel << extLow[10:9];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      baseQ  <= '0;
      idxQ   <= '0;
      disp8Q <= '0;
      ptrQ   <= '0;
      faultQ <= 1'b0;
    end else begin
      if (st.capture) begin
        cfgQ   <= cfgIn;
        baseQ  <= baseVal;
        idxQ   <= idxScaled;
        disp8Q <= {{(ADDR_W-LOW8_W){extLow[LOW8_W-1]}}, extLow[LOW8_W-1:0]};
        ptrQ   <= '0;
        faultQ <= 1'b0;
      end
      if (st.ptrFirst)  ptrQ[ADDR_W-1:HALF_W] <= memData;
      if (st.ptrSecond) ptrQ[HALF_W-1:0]      <= memData;
      if (st.setFault)  faultQ <= 1'b1;
    end
  end

  // base (g=0) and outer (g=1) displacement accumulators
  for (genvar g = 0; g < 2; g++) begin : gDisp
    logic firstLd;
    logic secondLd;
    logic longCode;
    if (g == 0) begin : gBase
      assign firstLd  = st.bdFirst;
      assign secondLd = st.bdSecond;
      assign longCode = (cfgQ.bdCode == 2'd3);
    end else begin : gOuter
      assign firstLd  = st.odFirst;
      assign secondLd = st.odSecond;
      assign longCode = (cfgQ.odCode == 2'd3);
    end
    idx_ea_disp #(.AW(ADDR_W), .HW(HALF_W)) i_disp (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (st.capture),
      .ldFirst (firstLd),
      .ldSecond(secondLd),
      .isLong  (longCode),
      .word    (fetchWord),
      .value   (dispVal[g])
    );
  end

  always_comb begin
    innerAddr = (cfgQ.suppress ? '0 : baseQ)
              + (cfgQ.brief ? disp8Q : dispVal[0])
              + ((cfgQ.brief | cfgQ.preIdx) ? idxQ : '0);
    outerAddr = ptrQ + dispVal[1] + (cfgQ.postIdx ? idxQ : '0);
    memAddr   = innerAddr + (st.selLow ? ADDR_W'(HALF_BYTES) : '0);
    eaOut     = (cfgQ.illegal | faultQ) ? '0 : (cfgQ.indir ? outerAddr : innerAddr);
    illegal   = cfgQ.illegal;
    fault     = faultQ;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> $stable(cfgQ)) else $error("cfg changed without capture"); // R11
  AST_PTR_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    st.setFault |-> !(st.ptrFirst || st.ptrSecond)) else $error("fault with pointer load"); // R10
endmodule

// File: rtl/idx_ea_ctrl.sv
module idx_ea_ctrl
  import idx_ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seq_cfg_t   seqIn,
  input  seq_cfg_t   seqQ,
  input  logic       fetchAck,
  input  logic       memAck,
  input  logic       memErr,
  output logic       fetchReq,
  output logic       memReq,
  output logic       busy,
  output logic       done,
  output dp_strobe_t st
);
  typedef enum logic [2:0] {
    S_IDLE, S_BD0, S_BD1, S_OD0, S_OD1, S_PTR0, S_PTR1, S_DONE
  } state_t;

  state_t state;
  state_t nxt;

  function automatic state_t afterOd(input seq_cfg_t c);
    return c.indir ? S_PTR0 : S_DONE;
  endfunction

  function automatic state_t afterBd(input seq_cfg_t c);
    return c.odCode[1] ? S_OD0 : afterOd(c);
  endfunction

  function automatic state_t afterCap(input seq_cfg_t c);
    if (c.brief || c.illegal) return S_DONE;
    return c.bdCode[1] ? S_BD0 : afterBd(c);
  endfunction

  always_comb begin
    st       = '0;
    nxt      = state;
    fetchReq = 1'b0;
    memReq   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          st.capture = 1'b1;
          nxt = afterCap(seqIn);
        end
      end
      S_BD0: begin
        fetchReq = 1'b1;
        if (fetchAck) begin
          st.bdFirst = 1'b1;
          nxt = (seqQ.bdCode == 2'd3) ? S_BD1 : afterBd(seqQ);
        end
      end
      S_BD1: begin
        fetchReq = 1'b1;
        if (fetchAck) begin
          st.bdSecond = 1'b1;
          nxt = afterBd(seqQ);
        end
      end
      S_OD0: begin
        fetchReq = 1'b1;
        if (fetchAck) begin
          st.odFirst = 1'b1;
          nxt = (seqQ.odCode == 2'd3) ? S_OD1 : afterOd(seqQ);
        end
      end
      S_OD1: begin
        fetchReq = 1'b1;
        if (fetchAck) begin
          st.odSecond = 1'b1;
          nxt = afterOd(seqQ);
        end
      end
      S_PTR0: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            st.setFault = 1'b1;
            nxt = S_DONE;
          end else begin
            st.ptrFirst = 1'b1;
            nxt = S_PTR1;
          end
        end
      end
      S_PTR1: begin
        memReq    = 1'b1;
        st.selLow = 1'b1;
        if (memAck) begin
          if (memErr) st.setFault = 1'b1;
          else        st.ptrSecond = 1'b1;
          nxt = S_DONE;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && memReq)) else $error("both ports requested"); // R9
  AST_BRIEF_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && seqIn.brief) |=> done) else $error("short form late"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R11
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy) else $error("busy dropped early"); // R11
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int REG_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [EXT_W-1:0]           extWord,
  input  logic [ADDR_W-1:0]          baseVal,
  output logic [$clog2(REG_CNT)-1:0] regSel,
  input  logic [ADDR_W-1:0]          regData,
  output logic                       fetchReq,
  input  logic                       fetchAck,
  input  logic [HALF_W-1:0]          fetchWord,
  output logic                       memReq,
  output logic [ADDR_W-1:0]          memAddr,
  input  logic                       memAck,
  input  logic                       memErr,
  input  logic [HALF_W-1:0]          memData,
  output logic                       busy,
  output logic                       done,
  output logic [ADDR_W-1:0]          eaOut,
  output logic                       illegal,
  output logic                       fault
);
  localparam int SEL_W = $clog2(REG_CNT);

  dp_strobe_t st;
  seq_cfg_t   seqIn;
  seq_cfg_t   seqQ;

  assign regSel = extWord[EXT_W-1 -: SEL_W];

  idx_ea_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .seqIn   (seqIn),
    .seqQ    (seqQ),
    .fetchAck(fetchAck),
    .memAck  (memAck),
    .memErr  (memErr),
    .fetchReq(fetchReq),
    .memReq  (memReq),
    .busy    (busy),
    .done    (done),
    .st      (st)
  );

  idx_ea_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .extLow   (extWord[11:0]),
    .baseVal  (baseVal),
    .regData  (regData),
    .fetchWord(fetchWord),
    .memData  (memData),
    .seqIn    (seqIn),
    .seqQ     (seqQ),
    .memAddr  (memAddr),
    .eaOut    (eaOut),
    .illegal  (illegal),
    .fault    (fault)
  );

  AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && extWord[8] && extWord[6] && extWord[2]) |=> (done && illegal))
    else $error("illegal encoding not flagged"); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr)) else $error("read address moved"); // R9
  AST_FAULT_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> $past(memReq && memAck && memErr)) else $error("fault without error"); // R10
endmodule

// File: tb/test_idx_ea_calc.sv
module test_idx_ea_calc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] extWord = '0;
  logic [31:0] baseVal = '0;
  logic [3:0]  regSel;
  logic [31:0] regData;
  logic        fetchReq, fetchAck;
  logic [15:0] fetchWord;
  logic        memReq, memAck, memErr;
  logic [31:0] memAddr;
  logic [15:0] memData;
  logic        busy, done, illegal, fault;
  logic [31:0] eaOut;

  int nChk = 0;
  int nBad = 0;
  logic [31:0] rf [16];
  logic [15:0] fq [4];
  int          fPtr = 0;
  bit          stallMode = 1'b0;
  bit          tgl = 1'b0;
  bit          errEn = 1'b0;
  logic [31:0] errAddr = '0;

  always #5 clk = ~clk;

  idx_ea_calc i_idx_ea_calc (
    .clk(clk), .rstN(rstN), .start(start), .extWord(extWord), .baseVal(baseVal),
    .regSel(regSel), .regData(regData), .fetchReq(fetchReq), .fetchAck(fetchAck),
    .fetchWord(fetchWord), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memErr(memErr), .memData(memData), .busy(busy), .done(done), .eaOut(eaOut),
    .illegal(illegal), .fault(fault)
  );

  function automatic logic [15:0] memWord(input logic [31:0] a);
    return a[15:0] ^ {a[31:24], a[7:0]} ^ 16'hC3A5;
  endfunction

  // bench-side responders
  always_comb begin
    regData   = rf[regSel];
    fetchAck  = fetchReq && (stallMode ? tgl : 1'b1);
    fetchWord = fq[fPtr & 3];
    memAck    = memReq;
    memData   = memWord(memAddr);
    memErr    = memReq && errEn && (memAddr == errAddr);
  end

  always @(posedge clk) begin
    tgl <= ~tgl;
    if (fetchReq && fetchAck) fPtr <= fPtr + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic refCalc(input logic [15:0] e, input logic [31:0] b, input logic [63:0] ws,
                         output logic [31:0] ea, output int lat, output bit ill,
                         output int words, output logic [31:0] inner);
    logic [15:0] w [4];
    logic [31:0] idx, bd, od, ptr;
    bit pre, post, indir;
    w[0] = ws[63:48]; w[1] = ws[47:32]; w[2] = ws[31:16]; w[3] = ws[15:0];
    idx = rf[e[15:12]];
    if (!e[11]) idx = {{16{idx[15]}}, idx[15:0]};
    idx = idx << e[10:9];
    words = 0; ill = 0; inner = '0; bd = '0; od = '0;
    if (!e[8]) begin
      inner = b + idx + {{24{e[7]}}, e[7:0]};
      ea = inner; lat = 1;
    end else if ((e[6] && e[2]) || e[3]) begin
      ill = 1; ea = '0; lat = 1;
    end else begin
      if (e[5:4] == 2'd2) begin bd = {{16{w[0][15]}}, w[0]}; words = 1; end
      else if (e[5:4] == 2'd3) begin bd = {w[0], w[1]}; words = 2; end
      if (e[1:0] == 2'd2) begin od = {{16{w[words][15]}}, w[words]}; words += 1; end
      else if (e[1:0] == 2'd3) begin od = {w[words], w[words+1]}; words += 2; end
      pre = !e[6] && !e[2];
      post = e[2] && !e[6];
      indir = (e[1:0] != 2'd0);
      inner = (e[7] ? 32'h0 : b) + bd + (pre ? idx : 32'h0);
      if (indir) begin
        ptr = {memWord(inner), memWord(inner + 32'd2)};
        ea = ptr + od + (post ? idx : 32'h0);
        lat = 1 + words + 2;
      end else begin
        ea = inner;
        lat = 1 + words;
      end
    end
  endtask

  task automatic runOne(input logic [15:0] e, input logic [31:0] b, input logic [63:0] ws,
                        input bit poke, output int lat);
    fq[0] = ws[63:48]; fq[1] = ws[47:32]; fq[2] = ws[31:16]; fq[3] = ws[15:0];
    @(negedge clk);
    fPtr = 0;
    extWord = e; baseVal = b; start = 1'b1;
    lat = 99;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (done) begin lat = n; break; end
      start = poke;
      if (poke) extWord = 16'h0144;
    end
    start = 1'b0;
  endtask

  localparam int NV = 12;
  // {ext, base, w0, w1, w2, w3}
  localparam logic [111:0] VEC [NV] = '{
    {16'h3480, 32'h0010_0000, 64'h0},                     // R1 R2 R3: word index, x4, negative disp
    {16'hAE7F, 32'h2000_0010, 64'h0},                     // R1 R2 R3: long index, x8
    {16'hF000, 32'hFFFF_FFF0, 64'h0},                     // R1 R2: reg 15, odd-valued word index
    {16'h5320, 32'h0000_8000, 64'hFFF0_0000_0000_0000},   // R5 R7: word base disp, pre-index
    {16'h19F0, 32'h1234_5678, 64'h0004_2000_0000_0000},   // R4 R5 R7: suppressed base, long disp, no index
    {16'h2D22, 32'h0003_0000, 64'h0010_8002_0000_0000},   // R6 R9: pre-indexed, word od
    {16'h7117, 32'h0040_0000, 64'h0001_0000_0000_0000},   // R6 R7 R9: post-indexed, long od
    {16'h01F1, 32'h5555_5555, 64'h0002_4000_0000_0000},   // R4 R6 R9: null od still indirect
    {16'h0144, 32'h0000_1000, 64'h0},                     // R8: both variant bits set
    {16'h0108, 32'h0000_1000, 64'h0},                     // R8: reserved bit 3
    {16'h9700, 32'h0000_0100, 64'h0},                     // R5: code 0 acts as null
    {16'h4B24, 32'h0008_0000, 64'h0100_0000_0000_0000}    // R7: post-index without indirection drops index
  };

  initial begin
    int lat, eLat, eWords;
    bit eIll;
    logic [31:0] eEa, eInner;
    for (int i = 0; i < 16; i++)
      rf[i] = {16'(i * 256 + 17), (i % 2 == 1) ? 16'(16'h8000 | (i * 837)) : 16'(i * 291)};
    for (int i = 0; i < 4; i++) fq[i] = '0;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", {31'b0, busy}, 32'd0);
    chk("R12 done", {31'b0, done}, 32'd0);
    chk("R12 fetchReq", {31'b0, fetchReq}, 32'd0);
    chk("R12 memReq", {31'b0, memReq}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string tag;
      logic [15:0] e;
      e = VEC[v][111:96];
      tag = !e[8] ? "R1" : (((e[6] && e[2]) || e[3]) ? "R8" : (e[1:0] != 0 ? "R9" : "R5"));
      refCalc(e, VEC[v][95:64], VEC[v][63:0], eEa, eLat, eIll, eWords, eInner);
      runOne(e, VEC[v][95:64], VEC[v][63:0], 1'b0, lat);
      chk({tag, " ea"}, eaOut, eEa);
      chk({tag, " latency"}, lat, eLat);
      chk({tag, " illegal"}, {31'b0, illegal}, {31'b0, eIll});
      chk("R6 words consumed", fPtr, eWords);
      chk("R10 no fault", {31'b0, fault}, 32'd0);
    end

    // R11: start held with an illegal word while busy
    refCalc(16'h2D22, 32'h0003_0000, 64'h0010_8002_0000_0000, eEa, eLat, eIll, eWords, eInner);
    runOne(16'h2D22, 32'h0003_0000, 64'h0010_8002_0000_0000, 1'b1, lat);
    chk("R11 ea unchanged", eaOut, eEa);
    chk("R11 latency", lat, eLat);
    chk("R11 illegal clear", {31'b0, illegal}, 32'd0);
    @(negedge clk);
    chk("R11 single done", {31'b0, done}, 32'd0);
    chk("R11 idle after", {31'b0, busy}, 32'd0);

    // R10: error on the lower half
    errEn = 1'b1; errAddr = eInner + 32'd2;
    runOne(16'h2D22, 32'h0003_0000, 64'h0010_8002_0000_0000, 1'b0, lat);
    chk("R10 fault low", {31'b0, fault}, 32'd1);
    chk("R10 ea zero", eaOut, 32'd0);
    chk("R10 latency low", lat, 1 + eWords + 2);
    // R10: error on the upper half stops before the second read
    errAddr = eInner;
    runOne(16'h2D22, 32'h0003_0000, 64'h0010_8002_0000_0000, 1'b0, lat);
    chk("R10 fault high", {31'b0, fault}, 32'd1);
    chk("R10 latency high", lat, 1 + eWords + 1);
    chk("R10 no read at done", {31'b0, memReq}, 32'd0);
    errEn = 1'b0;

    // R6: word order with a stalling word port
    stallMode = 1'b1;
    refCalc(16'h7117, 32'h0040_0000, 64'h0001_0000_0000_0000, eEa, eLat, eIll, eWords, eInner);
    runOne(16'h7117, 32'h0040_0000, 64'h0001_0000_0000_0000, 1'b0, lat);
    chk("R6 stalled ea", eaOut, eEa);
    refCalc(16'h19F0, 32'h1234_5678, 64'hFFFE_8000_0000_0000, eEa, eLat, eIll, eWords, eInner);
    runOne(16'h19F0, 32'h1234_5678, 64'hFFFE_8000_0000_0000, 1'b0, lat);
    chk("R5 stalled long ea", eaOut, eEa);
    stallMode = 1'b0;

    // R2: index select visible on regSel
    @(negedge clk);
    extWord = 16'hB000;
    #1;
    chk("R2 regSel", {28'b0, regSel}, 32'd11);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule